// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small stored-program processor built around one working register, the accumulator. Program and data share a single word-addressed memory reached through a synchronous port. Every instruction is one 16-bit word with one memory operand. The core reads the word, then reads its operand, then carries it out, so each instruction takes three clock cycles. Results leave the core only through store instructions.

A zero flag records whether the last load, add or subtract produced zero. A separate conditional jump tests that flag, and an unconditional jump always redirects the program counter. Together these let a program build counted loops with both forward and backward jumps. A halt instruction, or any opcode the core does not define, freezes the core and raises the `halted` output until the next reset.

Typical use: a sum such as L = I + J + K is written as one load, two adds and a store, followed by a halt. The constants I, J and K, and the cell L, sit in the same memory as the code.

Top module: `acc_core`

## Requirements
- R1: An instruction word carries its opcode in bits 15:12 and its operand address in bits 11:0. The memory port returns read data one clock after the address is presented.
- R2: Each instruction takes exactly three clock cycles. A straight-line program of n instructions that ends in a halt raises `halted` at the 3n-th rising edge after reset is released.
- R3: Opcode 0010 loads the memory word into the accumulator. Opcode 0001 adds the memory word to the accumulator. Opcode 0100 subtracts the memory word from the accumulator. All arithmetic wraps modulo 2^16.
- R4: Opcode 0011 writes the accumulator to the operand address. `mem_we` is asserted only during that instruction's third cycle.
- R5: Load, add and subtract set the zero flag to (result == 0). A store leaves the zero flag unchanged.
- R6: Opcode 0101 jumps to its address field when the zero flag is set and otherwise continues in sequence. Opcode 0110 always jumps to its address field. Targets may lie before or after the jump.
- R7: Opcode 0000, and every undefined opcode (0111 to 1111), raises `halted`. Once raised, `halted` stays high, no further memory write occurs, and the instruction's own effect is suppressed until reset.
- R8: After any instruction that neither jumps nor halts, the program counter advances by one.
- R9: Reset clears the accumulator, the program counter and the zero flag, and drops `halted`. The first fetch after reset comes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory address for fetch, operand read or store |
| mem_wdata | output | 16 | Store data (accumulator value) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| halted | output | 1 | High once a halt or undefined opcode has executed |

## Verification
The hardest case to reach from the ports is the zero flag itself. It is never visible directly, and it is observed only through whether a later conditional jump is taken.

The bench therefore places a store between the subtract and the jump, and a marker store that runs only on the fall-through path. It sweeps all pairs from a set of corner values, so that both the flag's setting and its survival across the store show up in memory.

A separate program makes a load clear a flag that a subtract had just set. A counted loop drives the backward and forward jumps through several iteration counts.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_ADD   = 4'h1;
  localparam logic [3:0] OP_LOAD  = 4'h2;
  localparam logic [3:0] OP_STORE = 4'h3;
  localparam logic [3:0] OP_SUB   = 4'h4;
  localparam logic [3:0] OP_BRZ   = 4'h5;
  localparam logic [3:0] OP_BR    = 4'h6;

  typedef enum logic [1:0] {
    PH_FETCH   = 2'd0,
    PH_OPERAND = 2'd1,
    PH_EXEC    = 2'd2,
    PH_STOP    = 2'd3
  } phase_e;

  typedef struct packed {
    logic load;
    logic add;
    logic sub;
    logic store;
    logic brz;
    logic br;
    logic stop;
  } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_core_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] opcode,
  output dec_t           dec
);

  always_comb begin
    dec = '0;
    case (opcode)
      OP_LOAD:  dec.load  = 1'b1;
      OP_ADD:   dec.add   = 1'b1;
      OP_SUB:   dec.sub   = 1'b1;
      OP_STORE: dec.store = 1'b1;
      OP_BRZ:   dec.brz   = 1'b1;
      OP_BR:    dec.br    = 1'b1;
      default:  dec.stop  = 1'b1;  // halt and all undefined codes
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic          do_load,
  input  logic          do_add,
  input  logic          do_sub,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] acc,
  output logic          zero_flag
);

  function automatic logic [DW-1:0] alu_result(
    input logic          ld,
    input logic          ad,
    input logic          sb,
    input logic [DW-1:0] a,
    input logic [DW-1:0] b
  );
    logic [DW-1:0] r;
    r = a;
    if (ld)      r = b;
    else if (ad) r = a + b;
    else if (sb) r = a - b;
    return r;
  endfunction

  logic [DW-1:0] result;
  logic          writes_acc;

  assign result     = alu_result(do_load, do_add, do_sub, acc, operand);
  assign writes_acc = exec_en & (do_load | do_add | do_sub);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      zero_flag <= 1'b0;
    end else if (writes_acc) begin
      acc       <= result;
      zero_flag <= (result == '0);
    end
  end

endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_core_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rdata,
  input  logic          is_br,
  input  logic          is_brz,
  input  logic          is_stop,
  input  logic          zero_flag,
  output phase_e        phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic          halted,
  output logic          branch_evt,
  output logic          stop_evt
);

  logic exec_now;

  assign exec_now   = (phase == PH_EXEC);
  assign branch_evt = exec_now & (is_br | (is_brz & zero_flag));
  assign stop_evt   = exec_now & is_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FETCH;
      pc     <= '0;
      ir     <= '0;
      halted <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH:   phase <= PH_OPERAND;
        PH_OPERAND: begin
          ir    <= rdata;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          if (stop_evt) begin
            halted <= 1'b1;
            phase  <= PH_STOP;
          end else begin
            phase <= PH_FETCH;
            pc    <= branch_evt ? ir[AW-1:0] : pc + 1'b1;
          end
        end
        default: phase <= PH_STOP;
      endcase
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  localparam int OPW = DW - AW;

  phase_e        phase;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;
  logic [AW-1:0] ir_addr;
  dec_t          dec;
  logic [DW-1:0] acc;
  logic          zero_flag;
  logic          exec_phase;
  logic          branch_evt;
  logic          stop_evt;

  assign ir_addr    = ir[AW-1:0];
  assign exec_phase = (phase == PH_EXEC);

  acc_decode #(.OPW(OPW)) u_dec (
    .opcode (ir[DW-1:AW]),
    .dec    (dec)
  );

  acc_sequencer #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdata      (mem_rdata),
    .is_br      (dec.br),
    .is_brz     (dec.brz),
    .is_stop    (dec.stop),
    .zero_flag  (zero_flag),
    .phase      (phase),
    .pc         (pc),
    .ir         (ir),
    .halted     (halted),
    .branch_evt (branch_evt),
    .stop_evt   (stop_evt)
  );

  acc_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_en   (exec_phase),
    .do_load   (dec.load),
    .do_add    (dec.add),
    .do_sub    (dec.sub),
    .operand   (mem_rdata),
    .acc       (acc),
    .zero_flag (zero_flag)
  );

  always_comb begin
    case (phase)
      PH_OPERAND: mem_addr = mem_rdata[AW-1:0];
      PH_EXEC:    mem_addr = ir_addr;
      default:    mem_addr = pc;
    endcase
  end

  assign mem_we    = exec_phase & dec.store;
  assign mem_wdata = acc;

endmodule

// File: rtl/acc_core_checker.sv
module acc_core_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic          mem_we,
  input logic          exec_phase,
  input logic          branch_evt,
  input logic          stop_evt,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ir_addr
);

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_no_write_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  assert_write_exec_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> exec_phase);

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && !branch_evt && !stop_evt) |=>
      (pc == $past(pc) + {{(AW-1){1'b0}}, 1'b1}));

  assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    branch_evt |=> (pc == $past(ir_addr)));

  assert_stop_raises_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> halted);

endmodule

bind acc_core acc_core_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halted     (halted),
  .mem_we     (mem_we),
  .exec_phase (exec_phase),
  .branch_evt (branch_evt),
  .stop_evt   (stop_evt),
  .pc         (pc),
  .ir_addr    (ir_addr)
);

// File: tb/acc_core_test.sv
module acc_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = '0;
  logic        halted;

  logic [15:0] mem [0:255];
  int n_checks = 0;
  int n_fails  = 0;
  int cyc_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(output int cycles);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cycles = 0;
    while (!halted && cycles < 2000) begin
      @(posedge clk);
      cycles++;
      #1;
    end
    @(negedge clk);
  endtask

  initial begin
    int cyc;
    logic [15:0] vals [6];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002;
    vals[3] = 16'h7FFF; vals[4] = 16'h8000; vals[5] = 16'hFFFF;

    // R9: reset state at the ports
    clear_mem();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 halted low in reset", {15'b0, halted}, 16'h0000);
    check("R9 no write in reset", {15'b0, mem_we}, 16'h0000);
    check("R9 fetch address zero", {4'h0, mem_addr}, 16'h0000);

    // R9: accumulator starts at zero (add then store)
    clear_mem();
    mem[0] = ins(4'h1, 12'h080);
    mem[1] = ins(4'h3, 12'h090);
    mem[2] = ins(4'h0, 12'h000);
    mem[8'h80] = 16'h1234;
    run(cyc);
    check("R9 accumulator cleared by reset", mem[8'h90], 16'h1234);

    // R3 R2 R8: load, add, add, store, halt with a sweep of operands
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [15:0] k;
        k = (i == 0 && j == 0) ? 16'd4 : vals[(i + j) % 6];
        clear_mem();
        mem[0] = ins(4'h2, 12'h080);
        mem[1] = ins(4'h1, 12'h081);
        mem[2] = ins(4'h1, 12'h082);
        mem[3] = ins(4'h3, 12'h083);
        mem[4] = ins(4'h0, 12'h000);
        mem[8'h80] = (i == 0 && j == 0) ? 16'd2 : vals[i];
        mem[8'h81] = (i == 0 && j == 0) ? 16'd3 : vals[j];
        mem[8'h82] = k;
        run(cyc);
        check("R3 sum with wrap", mem[8'h83], mem[8'h80] + mem[8'h81] + k);
        check("R2 halted at edge 3n", cyc[15:0], 16'd15);
      end
    end

    // R1 R3 R5 R6 R4: subtract, store, branch-if-zero across all value pairs
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        clear_mem();
        mem[0] = ins(4'h2, 12'h080);
        mem[1] = ins(4'h4, 12'h081);
        mem[2] = ins(4'h3, 12'h090);
        mem[3] = ins(4'h5, 12'h006);
        mem[4] = ins(4'h2, 12'h082);
        mem[5] = ins(4'h3, 12'h091);
        mem[6] = ins(4'h0, 12'h000);
        mem[8'h80] = vals[i];
        mem[8'h81] = vals[j];
        mem[8'h82] = 16'h0001;
        mem[8'h91] = 16'h5555;
        run(cyc);
        check("R3 difference", mem[8'h90], vals[i] - vals[j]);
        check("R5 R6 flag survives store, steers jump", mem[8'h91],
              (vals[i] == vals[j]) ? 16'h5555 : 16'h0001);
      end
    end

    // R6 R8: counted loop with backward BR and forward BRZ
    for (int n = 1; n <= 6; n++) begin
      clear_mem();
      mem[0] = ins(4'h2, 12'h080);
      mem[1] = ins(4'h4, 12'h081);
      mem[2] = ins(4'h3, 12'h080);
      mem[3] = ins(4'h5, 12'h008);
      mem[4] = ins(4'h2, 12'h082);
      mem[5] = ins(4'h1, 12'h083);
      mem[6] = ins(4'h3, 12'h082);
      mem[7] = ins(4'h6, 12'h000);
      mem[8] = ins(4'h0, 12'h000);
      mem[8'h80] = 16'(n);
      mem[8'h81] = 16'd1;
      mem[8'h83] = 16'd3;
      run(cyc);
      check("R6 loop total", mem[8'h82], 16'((n - 1) * 3));
      check("R6 loop counter", mem[8'h80], 16'h0000);
    end

    // R5: load clears a flag set by a subtract
    clear_mem();
    mem[0] = ins(4'h2, 12'h080);
    mem[1] = ins(4'h4, 12'h080);
    mem[2] = ins(4'h2, 12'h080);
    mem[3] = ins(4'h5, 12'h005);
    mem[4] = ins(4'h3, 12'h090);
    mem[5] = ins(4'h0, 12'h000);
    mem[8'h80] = 16'd5;
    run(cyc);
    check("R5 load updates flag", mem[8'h90], 16'd5);

    // R7: halt and every undefined opcode stop the core
    for (int op = 0; op < 16; op++) begin
      if (op >= 1 && op <= 6) continue;
      clear_mem();
      mem[0] = ins(4'h2, 12'h080);
      mem[1] = ins(4'(op), 12'h090);
      mem[2] = ins(4'h3, 12'h091);
      mem[8'h80] = 16'd5;
      run(cyc);
      check("R7 halted raised", {15'b0, halted}, 16'h0001);
      check("R7 stops at its own instruction", cyc[15:0], 16'd6);
      for (int w = 0; w < 8; w++) begin
        @(negedge clk);
        if (mem_we || !halted) begin
          check("R7 stays halted without writes", {14'b0, halted, mem_we}, 16'h0002);
        end
      end
      check("R7 no store after halt", mem[8'h91], 16'h0000);
      check("R7 opcode field not executed", mem[8'h90], 16'h0000);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule